// File: doc/BRIEF.md
# Wire-Class Transfer Steering

This block picks, for each data transfer leaving a cluster, one of three physical wire classes: the ordinary baseline link, a slower wide link tuned for low energy, or a fast link that carries only a few bits. The choice is made every cycle as a one-of-three demultiplex select. Per-transfer rules route short values to the fast link. Values that were already available when their consumer dispatched, and store data, are not on the critical path, so they go to the low-energy link.

On top of these rules, the block tracks how much traffic was injected into each of the two wide links over the last five cycles. When one link carries clearly more than the other, ordinary transfers are pushed to the quieter one until the gap closes. The link buffers and arbitration among transfers that compete for one link lie outside this block. It sees at most one transfer request per cycle and two per-cycle injection counts, and it returns a registered select one cycle later.

Top module: `xfer_lane_steer`

## Requirements
- R1: While reset is low, and in the first cycle after reset, `sel_valid_o` and `sel_o` are zero. The traffic windows start empty, so a plain request right after reset goes to the baseline link.
- R2: A request sampled at a clock edge produces `sel_valid_o`=1 after that same edge. When `sel_valid_o` is 1, `sel_o` has exactly one bit set: bit 0 baseline, bit 1 low-energy, bit 2 fast. When `sel_valid_o` is 0, `sel_o` is zero.
- R3: A request with `req_narrow_i`=1 selects the fast link (`sel_o`=3'b100). This holds whatever the other attributes are, and also while the imbalance override is active.
- R4: A non-narrow store-data request selects the low-energy link (3'b010) when no imbalance override is active.
- R5: A non-narrow request whose operand was ready at dispatch selects the low-energy link (3'b010) when no imbalance override is active.
- R6: A non-narrow request with neither the store nor the early-ready attribute selects the baseline link (3'b001) when no imbalance override is active.
- R7: The traffic seen for a request sampled at edge k is the sum, for each wide link, of the counts sampled at edges k-5 through k-1. A count stops counting five edges after it was sampled.
- R8: If the windowed baseline traffic exceeds the low-energy traffic by more than 10, every non-narrow request selects the low-energy link. If the low-energy traffic exceeds the baseline traffic by more than 10, every non-narrow request selects the baseline link, store data and early-ready operands included.
- R9: A difference of exactly 10 does not trigger the override.
- R10: The override is re-evaluated every cycle. Once the difference falls to 10 or below, the normal rules apply again at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | A transfer needs a link this cycle |
| req_narrow_i | input | 1 | Payload fits the fast narrow link (narrow value, low address bits, mispredict ID) |
| req_early_ready_i | input | 1 | Operand was already ready when its consumer dispatched |
| req_store_i | input | 1 | Payload is store data |
| base_inj_i | input | CNT_W (3) | Transfers injected into the baseline link this cycle |
| eco_inj_i | input | CNT_W (3) | Transfers injected into the low-energy link this cycle |
| sel_valid_o | output | 1 | `sel_o` holds a decision |
| sel_o | output | 3 | One-hot link select: bit 0 baseline, bit 1 low-energy, bit 2 fast |

## Verification
Each attribute is first tried alone with both windows empty. This separates the fast, low-energy and baseline rules from one another and from the reset state. Narrow requests are then mixed with store and early-ready flags, which confirms that the narrow rule wins.

Skewed traffic is then loaded in both directions. A baseline-heavy window must send a plain request to the low-energy link, and a low-energy-heavy window must pull store data back to the baseline link. A gap of exactly ten separates a `>` comparison from a `>=` comparison.

Finally, a short burst of traffic is followed by idle cycles, and requests are placed on either side of the fifth cycle. This shows that counts leave the window on the correct edge and that the override lifts as soon as the gap closes.

// File: rtl/steer_pkg.sv
// Package steer_pkg: the link-class encoding shared by the steering modules.
// Assumes the three classes are mutually exclusive for any single transfer.
package steer_pkg;
    typedef enum logic [1:0] {
        LANE_BASE = 2'd0,
        LANE_ECO  = 2'd1,
        LANE_FAST = 2'd2
    } lane_e;
endpackage

// File: rtl/inj_window.sv
// Module inj_window: keeps the per-cycle injection counts of one link for the
// last WIN_DEPTH cycles. A running sum is updated by adding the newest count
// and removing the one that leaves the window.
// Assumes: cnt_i is sampled at every clock edge, including idle cycles.
module inj_window #(
    parameter int WIN_DEPTH = 5,
    parameter int CNT_W     = 3,
    parameter int SUM_W     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [SUM_W-1:0] sum_o
);
    localparam logic [SUM_W-1:0] MAX_SUM = SUM_W'(WIN_DEPTH * ((1 << CNT_W) - 1));

    logic [CNT_W-1:0] hist_q [WIN_DEPTH];
    logic [SUM_W-1:0] sum_q;

    genvar g;
    generate
        for (g = 0; g < WIN_DEPTH; g++) begin : g_stage
            // One history stage: the first stage takes the new count, the others shift along.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    hist_q[g] <= '0;
                else if (g == 0)
                    hist_q[g] <= cnt_i;
                else
                    hist_q[g] <= hist_q[(g == 0) ? 0 : g - 1];
            end
        end
    endgenerate

    // Running sum: add the count entering the window, drop the one leaving it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sum_q <= '0;
        else
            sum_q <= sum_q + SUM_W'(cnt_i) - SUM_W'(hist_q[WIN_DEPTH-1]);
    end

    assign sum_o = sum_q;

    // R7: the running sum can never exceed a full window of maximum counts.
    a_r7_sum_cap: assert property (@(posedge clk) disable iff (!rst_n)
        sum_q <= MAX_SUM);
endmodule

// File: rtl/imbalance_detect.sv
// Module imbalance_detect: compares the windowed traffic of the two wide links.
// It flags an override when the gap is strictly above THRESH and names the
// quieter link. Purely combinational; it is re-evaluated every cycle.
module imbalance_detect #(
    parameter int SUM_W  = 6,
    parameter int THRESH = 10
) (
    input  logic [SUM_W-1:0] base_sum_i,
    input  logic [SUM_W-1:0] eco_sum_i,
    output logic             divert_o,
    output logic             to_eco_o
);
    logic [SUM_W:0] gap;

    // Absolute gap between the two windowed sums.
    always_comb begin
        if (base_sum_i >= eco_sum_i)
            gap = {1'b0, base_sum_i} - {1'b0, eco_sum_i};
        else
            gap = {1'b0, eco_sum_i} - {1'b0, base_sum_i};
    end

    assign divert_o = gap > (SUM_W + 1)'(THRESH);
    assign to_eco_o = base_sum_i > eco_sum_i;
endmodule

// File: rtl/lane_decide.sv
// Module lane_decide: applies the fixed rule precedence to one request.
// The order is narrow payload first, then the imbalance override, then the
// early-ready and store rules, with the baseline link as the default.
module lane_decide
    import steer_pkg::*;
(
    input  logic  narrow_i,
    input  logic  early_ready_i,
    input  logic  store_i,
    input  logic  divert_i,
    input  logic  to_eco_i,
    output lane_e lane_o
);
    // Priority chain of steering rules.
    always_comb begin
        if (narrow_i)
            lane_o = LANE_FAST;
        else if (divert_i)
            lane_o = to_eco_i ? LANE_ECO : LANE_BASE;
        else if (early_ready_i || store_i)
            lane_o = LANE_ECO;
        else
            lane_o = LANE_BASE;
    end
endmodule

// File: rtl/xfer_lane_steer.sv
// Module xfer_lane_steer: top of the wire-class steering block. It keeps one
// traffic window per wide link, detects imbalance, applies the rules and
// registers a one-hot select. Assumes at most one request per cycle; link
// buffering and arbitration happen downstream.
module xfer_lane_steer
    import steer_pkg::*;
#(
    parameter int WIN_DEPTH = 5,
    parameter int CNT_W     = 3,
    parameter int THRESH    = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid_i,
    input  logic             req_narrow_i,
    input  logic             req_early_ready_i,
    input  logic             req_store_i,
    input  logic [CNT_W-1:0] base_inj_i,
    input  logic [CNT_W-1:0] eco_inj_i,
    output logic             sel_valid_o,
    output logic [2:0]       sel_o
);
    localparam int SUM_W = CNT_W + $clog2(WIN_DEPTH + 1);

    logic [SUM_W-1:0] base_sum, eco_sum;
    logic             divert, to_eco;
    lane_e            lane;
    logic [2:0]       lane_hot;

    inj_window #(.WIN_DEPTH(WIN_DEPTH), .CNT_W(CNT_W), .SUM_W(SUM_W)) base_win_i (
        .clk(clk), .rst_n(rst_n), .cnt_i(base_inj_i), .sum_o(base_sum));

    inj_window #(.WIN_DEPTH(WIN_DEPTH), .CNT_W(CNT_W), .SUM_W(SUM_W)) eco_win_i (
        .clk(clk), .rst_n(rst_n), .cnt_i(eco_inj_i), .sum_o(eco_sum));

    imbalance_detect #(.SUM_W(SUM_W), .THRESH(THRESH)) detect_i (
        .base_sum_i(base_sum), .eco_sum_i(eco_sum),
        .divert_o(divert), .to_eco_o(to_eco));

    lane_decide decide_i (
        .narrow_i(req_narrow_i), .early_ready_i(req_early_ready_i),
        .store_i(req_store_i), .divert_i(divert), .to_eco_i(to_eco),
        .lane_o(lane));

    // Convert the chosen class into the one-hot demultiplex select.
    always_comb begin
        case (lane)
            LANE_FAST: lane_hot = 3'b100;
            LANE_ECO:  lane_hot = 3'b010;
            default:   lane_hot = 3'b001;
        endcase
    end

    // Output register: one decision per accepted request, zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_valid_o <= 1'b0;
            sel_o       <= '0;
        end else begin
            sel_valid_o <= req_valid_i;
            sel_o       <= req_valid_i ? lane_hot : 3'b000;
        end
    end

    // R2: a valid select is exactly one-hot.
    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid_o |-> $countones(sel_o) == 1);
    // R2: no select bits without a decision.
    a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid_o |-> sel_o == 3'b000);
    // R2: each request yields a decision on the next cycle.
    a_r2_req_resp: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> sel_valid_o);
    // R3: narrow payloads always take the fast link.
    a_r3_narrow_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_narrow_i) |=> sel_o == 3'b100);
    // R8: an active override toward the low-energy link is honoured.
    a_r8_divert_eco: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !req_narrow_i && divert && to_eco) |=> sel_o == 3'b010);
    // R8: an active override toward the baseline link is honoured.
    a_r8_divert_base: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !req_narrow_i && divert && !to_eco) |=> sel_o == 3'b001);
    // R4: store data goes to the low-energy link when no override is active.
    a_r4_store_eco: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_store_i && !req_narrow_i && !divert) |=> sel_o == 3'b010);
endmodule

// File: tb/xfer_lane_steer_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the cyc task drives one cycle and queues the expected select
// from an independent window model; the monitor pops and compares each result.
module xfer_lane_steer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid_i = 1'b0, req_narrow_i = 1'b0;
    logic       req_early_ready_i = 1'b0, req_store_i = 1'b0;
    logic [2:0] base_inj_i = '0, eco_inj_i = '0;
    logic       sel_valid_o;
    logic [2:0] sel_o;

    int n_checks = 0;
    int n_bad = 0;
    int n_push = 0;
    int n_pop = 0;
    logic [2:0] exp_q[$];
    string      tag_q[$];
    int mb[5];
    int me[5];

    always #2 clk = ~clk;

    xfer_lane_steer dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i),
        .req_narrow_i(req_narrow_i), .req_early_ready_i(req_early_ready_i),
        .req_store_i(req_store_i), .base_inj_i(base_inj_i), .eco_inj_i(eco_inj_i),
        .sel_valid_o(sel_valid_o), .sel_o(sel_o));

    task automatic check(string tag, logic [2:0] got, logic [2:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%b exp=%b", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    endtask

    // One driven cycle: compute the expected select from the model, then shift the counts in.
    task automatic cyc(bit v, bit n, bit r, bit s, int bc, int ec, string tag);
        int sb = 0;
        int se = 0;
        int gap;
        logic [2:0] exp;
        @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            sb += mb[i];
            se += me[i];
        end
        gap = (sb > se) ? sb - se : se - sb;
        if (n)              exp = 3'b100;
        else if (gap > 10)  exp = (sb > se) ? 3'b010 : 3'b001;
        else if (r || s)    exp = 3'b010;
        else                exp = 3'b001;
        if (v) begin
            exp_q.push_back(exp);
            tag_q.push_back(tag);
            n_push++;
        end
        req_valid_i = v;
        req_narrow_i = n;
        req_early_ready_i = r;
        req_store_i = s;
        base_inj_i = 3'(bc);
        eco_inj_i = 3'(ec);
        for (int i = 4; i > 0; i--) begin
            mb[i] = mb[i-1];
            me[i] = me[i-1];
        end
        mb[0] = bc;
        me[0] = ec;
    endtask

    // Monitor: compare every decision against the oldest queued expectation.
    always @(negedge clk) begin
        if (rst_n) begin
            if (sel_valid_o) begin
                if (exp_q.size() == 0) begin
                    check("R2 spurious valid", 3'b111, 3'b000);
                end else begin
                    check(tag_q.pop_front(), sel_o, exp_q.pop_front());
                    n_pop++;
                end
            end else if (sel_o !== 3'b000) begin
                check("R2 select without valid", sel_o, 3'b000);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog expired got=running exp=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 5; i++) begin
            mb[i] = 0;
            me[i] = 0;
        end
        // R1: requests and traffic during reset must leave no trace.
        req_valid_i = 1'b1;
        req_narrow_i = 1'b1;
        base_inj_i = 3'd7;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 valid in reset", {2'b0, sel_valid_o}, 3'b000);
        check("R1 select in reset", sel_o, 3'b000);
        rst_n = 1'b1;
        req_valid_i = 1'b0;
        req_narrow_i = 1'b0;
        base_inj_i = '0;
        @(negedge clk);
        check("R1 valid after reset", {2'b0, sel_valid_o}, 3'b000);
        check("R1 select after reset", sel_o, 3'b000);

        cyc(1, 0, 0, 0, 0, 0, "R1 R6 plain after reset to baseline");
        cyc(1, 1, 0, 0, 0, 0, "R3 narrow to fast");
        cyc(1, 0, 0, 1, 0, 0, "R4 store to low-energy");
        cyc(1, 0, 1, 0, 0, 0, "R5 early-ready to low-energy");
        cyc(1, 1, 1, 1, 0, 0, "R3 narrow beats store and early-ready");
        cyc(1, 0, 0, 0, 0, 0, "R6 plain to baseline");
        cyc(0, 0, 0, 0, 0, 0, "idle");

        // Baseline-heavy window: 15 against 0.
        for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 3, 0, "fill");
        cyc(1, 0, 0, 0, 0, 0, "R8 baseline heavy diverts plain to low-energy");
        cyc(1, 1, 0, 0, 0, 0, "R3 narrow under override");
        cyc(1, 0, 0, 0, 0, 0, "R10 gap 9 lifts override");
        for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 0, 0, "drain");

        // Gap of exactly 10.
        for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 2, 0, "fill");
        cyc(1, 0, 0, 0, 0, 0, "R9 gap of ten keeps baseline");
        for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 0, 0, "drain");

        // Low-energy-heavy window: 11 against 0.
        cyc(0, 0, 0, 0, 0, 3, "fill");
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 2, "fill");
        cyc(1, 0, 0, 1, 0, 0, "R8 low-energy heavy pulls store to baseline");
        cyc(1, 0, 1, 0, 0, 0, "R5 R10 gap 8 early-ready back to low-energy");
        for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 0, 0, "drain");

        // Aging: burst of 7+7 and then idle.
        cyc(0, 0, 0, 0, 7, 0, "burst");
        cyc(0, 0, 0, 0, 7, 0, "burst");
        cyc(0, 0, 0, 0, 0, 0, "gap");
        cyc(0, 0, 0, 0, 0, 0, "gap");
        cyc(0, 0, 0, 0, 0, 0, "gap");
        cyc(1, 0, 0, 0, 0, 0, "R7 both burst counts still in window");
        cyc(1, 0, 0, 0, 0, 0, "R7 R10 first burst count aged out");
        cyc(0, 0, 0, 0, 0, 0, "flush");
        cyc(0, 0, 0, 0, 0, 0, "flush");

        check("R2 every request answered", 3'(n_pop == n_push), 3'b001);
        finish_run();
    end
endmodule